// File: doc/BRIEF.md
# Road Combination Linear Track Fitter

This block takes one road at a time from a pattern-matching stage. A road holds up to four hit coordinates on each of eleven detector layers. The block lists every candidate track that uses exactly one hit per layer. For each candidate it evaluates a linear fit: eleven result rows, each the dot product of one row of a preloaded signed constant matrix with the candidate's coordinate vector, plus a per-row offset. The first five rows are output as track parameters. The remaining six rows are residual terms, and their squares are summed into a chi-square.

A layer with a hit count of zero is a missing layer. A road may have at most one. The missing layer adds no choices to the enumeration, and its coordinate is forced to zero in every candidate of that road. Constants are written one word per cycle through a plain write port while the block is idle.

The road input and the fitted-track output both use valid/ready. A road is taken when `in_valid` and `in_ready` are both high on a rising edge. `in_ready` is high only while no road is in progress. An output candidate is consumed when `out_valid` and `out_ready` are both high. While `out_ready` is low, the presented candidate and all of its fields are held unchanged. A new road is accepted only after the candidate flagged last has been consumed.

Top module: `ltf_fitter`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and every constant is zero.
- R2: The candidates of a road are emitted in odometer order, with the hit slot of layer 0 changing fastest. `out_comb_idx` starts at 0 and rises by one per candidate. The number of candidates equals the product of the effective per-layer counts.
- R3: Result row i equals q[i] plus the sum over j of C[i][j]·x[j], modulo 2^32, with signed arithmetic. x[j] is the 12-bit signed coordinate of the chosen slot k on layer j, located at `in_hits` bits [(j*4+k)*12 +: 12].
- R4: `out_par` carries rows 0..4, with row i at bits [32*i +: 32]. `out_chi2` is the sum of the squares of rows 5..10, modulo 2^64.
- R5: A road with exactly one layer whose `in_cnt` field (bits [3*j +: 3]) is zero is fitted. That layer contributes x = 0 and adds no choices to the enumeration.
- R6: A road with two or more zero-count layers is consumed. It produces no candidate, and `in_ready` is high again on the next cycle.
- R7: `out_last` is 1 only on the final candidate of a road. `out_valid` and `in_ready` are never high together. `in_ready` returns to 1 after the last candidate is consumed.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and every output field stay unchanged on the next cycle.
- R9: With `cfg_we` high, `cfg_col` 0..10 writes C[`cfg_row`][`cfg_col`] and `cfg_col` 11 writes q[`cfg_row`]. A write with `cfg_row` ≥ 11 or `cfg_col` ≥ 12 changes nothing.
- R10: A layer count above 4 is treated as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Road offered |
| in_ready | output | 1 | Block idle, road can be taken |
| in_road_id | input | 8 | Road tag, copied onto each candidate |
| in_cnt | input | 33 | Hit count per layer, 3 bits each |
| in_hits | input | 528 | Coordinates, 4 slots × 12 bits per layer |
| cfg_we | input | 1 | Constant write strobe |
| cfg_row | input | 4 | Result row of the constant |
| cfg_col | input | 4 | Matrix column 0..10, or 11 for the offset |
| cfg_data | input | 16 | Signed constant value |
| out_valid | output | 1 | Candidate presented |
| out_ready | input | 1 | Sink takes the candidate |
| out_road_id | output | 8 | Tag of the road |
| out_comb_idx | output | 22 | Candidate index within the road |
| out_last | output | 1 | Final candidate of the road |
| out_par | output | 160 | Five 32-bit track parameters |
| out_chi2 | output | 64 | Sum of the squared residual rows |

## Verification
The hardest situation to reach from the ports is a long odometer carry while the sink is stalling. In this case several layers wrap at once, and the held candidate must not move. The stimulus uses roads with mixed counts (2, 3 and a clamped 7) together with a pseudo-random `out_ready` that drops about one cycle in four. Carries across several layers therefore coincide with stalls. The roads with one or two empty layers, and the writes to illegal rows and columns, are placed between normal roads. Any leftover effect then shows up in the numbers of the next fitted candidate.

// File: rtl/ltf_pkg.sv
package ltf_pkg;
  parameter int NCOORD = 11;
  parameter int NPAR   = 5;
  parameter int MAXHIT = 4;
  parameter int CW     = 12;
  parameter int KW     = 16;
  parameter int AW     = 32;
  parameter int CNTW   = 3;
  parameter int IDW    = 8;

  localparam int NROW  = NCOORD;
  localparam int HSELW = $clog2(MAXHIT);
  localparam int COLW  = $clog2(NCOORD + 2);
  localparam int ROWW  = $clog2(NROW + 1);
  localparam int COMBW = HSELW * NCOORD;
  localparam int CHIW  = 2 * AW;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_OUT  = 2'd2
  } fit_state_t;
endpackage

// File: rtl/ltf_const_bank.sv
module ltf_const_bank
  import ltf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [ROWW-1:0]        wr_row,
  input  logic [COLW-1:0]        wr_col,
  input  logic signed [KW-1:0]   wr_data,
  input  logic [COLW-1:0]        rd_col,
  output logic [NROW*KW-1:0]     coef_col,
  output logic [NROW*KW-1:0]     offs
);
  logic signed [KW-1:0] mem [NROW][NCOORD+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NROW; i++)
        for (int j = 0; j <= NCOORD; j++)
          mem[i][j] <= '0;
    end else if (we) begin
      for (int i = 0; i < NROW; i++)
        for (int j = 0; j <= NCOORD; j++)
          if (wr_row == ROWW'(i) && wr_col == COLW'(j))
            mem[i][j] <= wr_data;
    end
  end

  always_comb begin
    coef_col = '0;
    for (int i = 0; i < NROW; i++) begin
      offs[i*KW +: KW] = mem[i][NCOORD];
      for (int j = 0; j < NCOORD; j++)
        if (rd_col == COLW'(j))
          coef_col[i*KW +: KW] = mem[i][j];
    end
  end
endmodule

// File: rtl/ltf_comb_gen.sv
module ltf_comb_gen
  import ltf_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     step,
  input  logic [NCOORD*CNTW-1:0]   cnt_in,
  output logic                     multi_empty,
  output logic [NCOORD*HSELW-1:0]  sel,
  output logic [NCOORD-1:0]        miss,
  output logic                     last,
  output logic [COMBW-1:0]         idx
);
  logic [NCOORD*HSELW-1:0] lim_in, lim_q, sel_nxt;
  logic [NCOORD-1:0]       miss_in;
  logic [CNTW-1:0]         c;
  logic                    carry;
  int                      nempty;

  always_comb begin
    nempty = 0;
    for (int l = 0; l < NCOORD; l++) begin
      c = cnt_in[l*CNTW +: CNTW];
      miss_in[l] = (c == '0);
      if (c == '0)
        lim_in[l*HSELW +: HSELW] = '0;
      else if (c > CNTW'(MAXHIT))
        lim_in[l*HSELW +: HSELW] = HSELW'(MAXHIT - 1);
      else
        lim_in[l*HSELW +: HSELW] = HSELW'(c - CNTW'(1));
      if (c == '0) nempty = nempty + 1;
    end
    multi_empty = (nempty > 1);
  end

  always_comb begin
    carry = 1'b1;
    last  = 1'b1;
    for (int l = 0; l < NCOORD; l++) begin
      sel_nxt[l*HSELW +: HSELW] = sel[l*HSELW +: HSELW];
      if (sel[l*HSELW +: HSELW] != lim_q[l*HSELW +: HSELW]) last = 1'b0;
      if (carry) begin
        if (sel[l*HSELW +: HSELW] == lim_q[l*HSELW +: HSELW]) begin
          sel_nxt[l*HSELW +: HSELW] = '0;
        end else begin
          sel_nxt[l*HSELW +: HSELW] = sel[l*HSELW +: HSELW] + HSELW'(1);
          carry = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q <= '0;
      miss  <= '0;
      sel   <= '0;
      idx   <= '0;
    end else if (load) begin
      lim_q <= lim_in;
      miss  <= miss_in;
      sel   <= '0;
      idx   <= '0;
    end else if (step) begin
      sel   <= sel_nxt;
      idx   <= idx + COMBW'(1);
    end
  end
endmodule

// File: rtl/ltf_mac_row.sv
module ltf_mac_row
  import ltf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 en,
  input  logic signed [KW-1:0] init,
  input  logic signed [KW-1:0] coef,
  input  logic signed [CW-1:0] x,
  output logic signed [AW-1:0] acc
);
  logic signed [AW-1:0] prod;

  always_comb prod = AW'(coef) * AW'(x);

  always_ff @(posedge clk) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= AW'(init);
    else if (en)    acc <= acc + prod;
  end
endmodule

// File: rtl/ltf_chi_sum.sv
module ltf_chi_sum
  import ltf_pkg::*;
(
  input  logic [NROW*AW-1:0] rows,
  output logic [CHIW-1:0]    chi
);
  logic signed [AW-1:0]   r;
  logic signed [CHIW-1:0] sq;

  always_comb begin
    chi = '0;
    for (int i = NPAR; i < NROW; i++) begin
      r   = rows[i*AW +: AW];
      sq  = CHIW'(r) * CHIW'(r);
      chi = chi + sq;
    end
  end
endmodule

// File: rtl/ltf_fitter.sv
module ltf_fitter
  import ltf_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [IDW-1:0]                in_road_id,
  input  logic [NCOORD*CNTW-1:0]        in_cnt,
  input  logic [NCOORD*MAXHIT*CW-1:0]   in_hits,
  input  logic                          cfg_we,
  input  logic [ROWW-1:0]               cfg_row,
  input  logic [COLW-1:0]               cfg_col,
  input  logic [KW-1:0]                 cfg_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [IDW-1:0]                out_road_id,
  output logic [COMBW-1:0]              out_comb_idx,
  output logic                          out_last,
  output logic [NPAR*AW-1:0]            out_par,
  output logic [CHIW-1:0]               out_chi2
);
  fit_state_t                  state;
  logic [COLW-1:0]             col_q;
  logic [IDW-1:0]              id_q;
  logic [NCOORD*MAXHIT*CW-1:0] hits_q;
  logic [NROW*KW-1:0]          coef_col, offs;
  logic [NROW*AW-1:0]          acc_flat;
  logic [NCOORD*HSELW-1:0]     sel;
  logic [NCOORD-1:0]           miss;
  logic                        last, multi_empty;
  logic                        accept, out_fire, acc_clear, mac_en, step;
  logic signed [CW-1:0]        x_cur;
  logic [HSELW-1:0]            slot;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_OUT);
  assign accept    = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign step      = out_fire && !last;
  assign acc_clear = (accept && !multi_empty) || step;
  assign mac_en    = (state == ST_MAC);

  ltf_const_bank u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wr_row(cfg_row), .wr_col(cfg_col),
    .wr_data(cfg_data), .rd_col(col_q), .coef_col(coef_col), .offs(offs)
  );

  ltf_comb_gen u_comb (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(step), .cnt_in(in_cnt),
    .multi_empty(multi_empty), .sel(sel), .miss(miss), .last(last), .idx(out_comb_idx)
  );

  always_comb begin
    x_cur = '0;
    slot  = '0;
    for (int l = 0; l < NCOORD; l++) begin
      if (col_q == COLW'(l)) begin
        slot = sel[l*HSELW +: HSELW];
        if (!miss[l])
          x_cur = hits_q[(l*MAXHIT + int'(slot))*CW +: CW];
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NROW; gi++) begin : g_row
      ltf_mac_row u_row (
        .clk(clk), .rst_n(rst_n), .clear(acc_clear), .en(mac_en),
        .init(offs[gi*KW +: KW]), .coef(coef_col[gi*KW +: KW]), .x(x_cur),
        .acc(acc_flat[gi*AW +: AW])
      );
    end
  endgenerate

  ltf_chi_sum u_chi (.rows(acc_flat), .chi(out_chi2));

  assign out_par     = acc_flat[NPAR*AW-1:0];
  assign out_road_id = id_q;
  assign out_last    = last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      col_q  <= '0;
      id_q   <= '0;
      hits_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          id_q   <= in_road_id;
          hits_q <= in_hits;
          col_q  <= '0;
          if (!multi_empty) state <= ST_MAC;
        end
        ST_MAC: begin
          if (col_q == COLW'(NCOORD - 1)) state <= ST_OUT;
          else col_q <= col_q + COLW'(1);
        end
        ST_OUT: if (out_fire) begin
          col_q <= '0;
          state <= last ? ST_IDLE : ST_MAC;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ltf_fit_chk.sv
module ltf_fit_chk
  import ltf_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic                 out_last,
  input logic [COMBW-1:0]     out_comb_idx,
  input logic [IDW-1:0]       out_road_id,
  input logic [NPAR*AW-1:0]   out_par,
  input logic [CHIW-1:0]      out_chi2
);
  logic             have_prev, prev_last;
  logic [COMBW-1:0] prev_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_last <= 1'b0;
      prev_idx  <= '0;
    end else if (out_valid && out_ready) begin
      have_prev <= 1'b1;
      prev_last <= out_last;
      prev_idx  <= out_comb_idx;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (in_ready && !out_valid));

  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && have_prev && !prev_last) |-> out_comb_idx == prev_idx + COMBW'(1));

  p_idx_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (!have_prev || prev_last)) |-> out_comb_idx == '0);

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_ready_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> in_ready);

  p_taken_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_comb_idx) && $stable(out_last)
      && $stable(out_road_id) && $stable(out_par) && $stable(out_chi2)));
endmodule

bind ltf_fitter ltf_fit_chk u_fit_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
  .out_comb_idx(out_comb_idx), .out_road_id(out_road_id), .out_par(out_par),
  .out_chi2(out_chi2)
);

// File: tb/test_ltf_fitter.sv
module test_ltf_fitter;
  import ltf_pkg::*;

  logic                          clk = 1'b0;
  logic                          rst_n = 1'b0;
  logic                          in_valid = 1'b0;
  logic                          in_ready;
  logic [IDW-1:0]                in_road_id = '0;
  logic [NCOORD*CNTW-1:0]        in_cnt = '0;
  logic [NCOORD*MAXHIT*CW-1:0]   in_hits = '0;
  logic                          cfg_we = 1'b0;
  logic [ROWW-1:0]               cfg_row = '0;
  logic [COLW-1:0]               cfg_col = '0;
  logic [KW-1:0]                 cfg_data = '0;
  logic                          out_valid;
  logic                          out_ready = 1'b0;
  logic [IDW-1:0]                out_road_id;
  logic [COMBW-1:0]              out_comb_idx;
  logic                          out_last;
  logic [NPAR*AW-1:0]            out_par;
  logic [CHIW-1:0]               out_chi2;

  always #4 clk = ~clk;

  ltf_fitter i_ltf_fitter (.*);

  typedef struct {
    logic [IDW-1:0]     id;
    int                 idx;
    bit                 last;
    logic [NPAR*AW-1:0] par;
    logic [CHIW-1:0]    chi;
    string              req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   m_c[NROW][NCOORD+1];
  int   r_cnt[NCOORD];
  int   r_hit[NCOORD][MAXHIT];

  task automatic chk(bit ok, string req, string what, logic [CHIW-1:0] act, logic [CHIW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic load(int row, int col, int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = ROWW'(row); cfg_col = COLW'(col); cfg_data = KW'(val);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    if (row < NROW && col <= NCOORD) m_c[row][col] = int'($signed(KW'(val)));
  endtask

  task automatic set_road(int seed);
    for (int l = 0; l < NCOORD; l++) begin
      r_cnt[l] = 1;
      for (int k = 0; k < MAXHIT; k++)
        r_hit[l][k] = ((l*37 + k*53 + seed*11) % 4096) - 2048;
    end
  endtask

  task automatic send_road(logic [IDW-1:0] id, string req);
    int eff[NCOORD];
    int total, nempty, rem, d;
    int x[NCOORD];
    int acc[NROW];
    longint s;
    exp_t e;
    total = 1; nempty = 0;
    for (int l = 0; l < NCOORD; l++) begin
      eff[l] = (r_cnt[l] == 0) ? 1 : ((r_cnt[l] > MAXHIT) ? MAXHIT : r_cnt[l]);
      if (r_cnt[l] == 0) nempty++;
      total = total * eff[l];
      in_cnt[l*CNTW +: CNTW] = CNTW'(r_cnt[l]);
      for (int k = 0; k < MAXHIT; k++)
        in_hits[(l*MAXHIT + k)*CW +: CW] = CW'(r_hit[l][k]);
    end
    if (nempty > 1) total = 0;
    for (int n = 0; n < total; n++) begin
      rem = n;
      for (int l = 0; l < NCOORD; l++) begin
        d = rem % eff[l];
        rem = rem / eff[l];
        x[l] = (r_cnt[l] == 0) ? 0 : r_hit[l][d];
      end
      s = 0;
      for (int i = 0; i < NROW; i++) begin
        acc[i] = m_c[i][NCOORD];
        for (int j = 0; j < NCOORD; j++) acc[i] = acc[i] + m_c[i][j] * x[j];
        if (i < NPAR) e.par[i*AW +: AW] = acc[i];
        else s = s + longint'(acc[i]) * longint'(acc[i]);
      end
      e.id = id; e.idx = n; e.last = (n == total - 1); e.chi = s; e.req = req;
      exp_q.push_back(e);
    end
    in_road_id = id;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (total > 0) chk(in_ready == 1'b0, "R7", "in_ready busy", CHIW'(in_ready), 0);
    else chk(in_ready && !out_valid, "R6", "two-empty road dropped", CHIW'({in_ready, out_valid}), 2);
    while (!(exp_q.size() == 0 && in_ready)) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    logic [15:0] lfsr = 16'hACE1;
    bit stalled = 0;
    logic [COMBW-1:0] s_idx;
    logic [NPAR*AW-1:0] s_par;
    logic [CHIW-1:0] s_chi;
    exp_t e;
    forever begin
      @(negedge clk);
      if (stalled) begin
        chk(out_valid && out_comb_idx == s_idx && out_par == s_par && out_chi2 == s_chi,
            "R8", "held candidate", CHIW'(out_comb_idx), CHIW'(s_idx));
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[3];
      stalled = out_valid && !out_ready;
      s_idx = out_comb_idx; s_par = out_par; s_chi = out_chi2;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected candidate", CHIW'(out_comb_idx), 0);
        end else begin
          e = exp_q.pop_front();
          chk(out_road_id == e.id, e.req, "road id", CHIW'(out_road_id), CHIW'(e.id));
          chk(out_comb_idx == COMBW'(e.idx), "R2", "comb idx", CHIW'(out_comb_idx), CHIW'(e.idx));
          chk(out_last == e.last, "R7", "last flag", CHIW'(out_last), CHIW'(e.last));
          for (int i = 0; i < NPAR; i++)
            chk(out_par[i*AW +: AW] == e.par[i*AW +: AW], e.req, "param row (R3)",
                CHIW'(out_par[i*AW +: AW]), CHIW'(e.par[i*AW +: AW]));
          chk(out_chi2 == e.chi, e.req, "chi2 (R4)", out_chi2, e.chi);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NROW; i++)
      for (int j = 0; j <= NCOORD; j++) m_c[i][j] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "reset state", CHIW'({in_ready, out_valid}), 2);

    // R1: constants zero after reset -> all rows zero
    set_road(1);
    send_road(8'h01, "R1");

    for (int i = 0; i < NROW; i++) begin
      for (int j = 0; j < NCOORD; j++) load(i, j, ((i*7 + j*3) % 23) - 11);
      load(i, NCOORD, i*100 - 300);
    end

    // R3/R4: single candidate road
    set_road(2);
    send_road(8'h02, "R3");

    // R2: mixed counts, odometer order
    set_road(3);
    r_cnt[0] = 2; r_cnt[1] = 3; r_cnt[6] = 2;
    send_road(8'h03, "R2");

    // R5: one empty layer
    set_road(4);
    r_cnt[5] = 0; r_cnt[2] = 2; r_cnt[10] = 4;
    send_road(8'h04, "R5");

    // R6: two empty layers, then a normal road
    set_road(5);
    r_cnt[1] = 0; r_cnt[7] = 0; r_cnt[3] = 3;
    send_road(8'h05, "R6");
    set_road(6);
    r_cnt[4] = 2;
    send_road(8'h06, "R6");

    // R10: count 7 clamped to 4
    set_road(7);
    r_cnt[3] = 7; r_cnt[9] = 2;
    send_road(8'h07, "R10");

    // R9: legal rewrites and ignored writes
    load(3, 2, 1234);
    load(8, NCOORD, -777);
    load(11, 0, 3000);
    load(13, 4, -3000);
    load(2, 12, 2500);
    load(0, 15, 999);
    set_road(8);
    r_cnt[2] = 3; r_cnt[0] = 2;
    send_road(8'h08, "R9");

    // R4: extreme coordinates
    set_road(9);
    for (int l = 0; l < NCOORD; l++) begin r_hit[l][0] = -2048; r_hit[l][1] = 2047; end
    r_cnt[0] = 2; r_cnt[10] = 2;
    send_road(8'h09, "R4");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "all candidates seen", CHIW'(exp_q.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule